// File: doc/BRIEF.md
# Serial Audio Port Buffer and Status Logic

This block holds the one-word data buffers and the status and interrupt logic of a serial audio port that runs either as a receiver or as a transmitter. When receiving, the shift register hands each finished word to a one-entry receive buffer that software reads. When transmitting, software writes a one-entry transmit buffer, and the shift register empties it when it takes the word. Bit clocking, framing and the bus decoding are not part of the block. The shift side is reduced to strobes, and the bus side is a simple register port with combinational read data.

The block detects overflow in the active direction and records it in a sticky flag. Software clears that flag only by writing 0 to its bit. It also mirrors a live idle indication that software can poll but cannot clear. One registered interrupt line combines both flags with their enable bits.

Top module: `audio_buf_status`

## Requirements
- R1: After reset, the control word, the status word, both buffer-full indications, the transmit buffer and `irq` are all 0.
- R2: The status word (address 1) holds the overflow flag at bit 26. The flag becomes 1 on the clock edge after an overflow event, whatever the overflow interrupt enable is set to.
- R3: In receive mode (`txMode`=0), a `shiftRxValid` strobe while the receive buffer is full and not being read in the same cycle is an overflow. The new word always replaces the buffered word, and the receive data read at address 2 returns it zero-extended.
- R4: In transmit mode (`txMode`=1), a write to address 3 while the transmit buffer is full and `shiftTxTake` is not active in the same cycle is an overflow. The written word replaces the buffered word.
- R5: Only the direction selected by `txMode` can raise an overflow. Receive loads in transmit mode, and transmit writes in receive mode, never set the flag.
- R6: Writing the status word with bit 26 at 0 clears the overflow flag, and writing it with bit 26 at 1 leaves the flag unchanged. When a clearing write and an overflow event fall in the same cycle, the flag ends at 1.
- R7: Status bit 25 shows `portIdle` as sampled at the previous clock edge, independent of the idle interrupt enable. Writes to the status word have no effect on it.
- R8: `irq` is a register that becomes, one cycle later, (overflow flag AND overflow enable) OR (idle flag AND idle enable).
- R9: The receive-full indication is status bit 0 and the transmit-full indication is status bit 1. A read strobe at address 2 clears receive-full unless a load happens in the same cycle. `shiftTxTake` clears transmit-full unless a write happens in the same cycle. `shiftTxData` always shows the transmit buffer.
- R10: The control word sits at address 0, with the overflow interrupt enable at bit 0 and the idle interrupt enable at bit 1. Both bits are read back as written, and all other read bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| txMode | input | 1 | Direction: 0 receive, 1 transmit |
| portIdle | input | 1 | Live idle condition from the port sequencer |
| shiftRxValid | input | 1 | Shift register delivers a received word |
| shiftRxData | input | DATA_W | Received word |
| shiftTxTake | input | 1 | Shift register takes the transmit buffer word |
| shiftTxData | output | DATA_W | Contents of the transmit buffer |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (side effect at address 2) |
| regAddr | input | ADDR_W | Register address |
| regWrData | input | BUS_W | Write data |
| regRdData | output | BUS_W | Combinational read data for `regAddr` |
| irq | output | 1 | Registered interrupt request |

## Verification
The bench targets the same-cycle collisions. A read that meets a load must not count as an overflow, and a take that meets a write must not count either. A design that ignored the collision would raise false overflows or lose the full indication. It drives a clearing write into the cycle of an overflow, because a design where the clear wins would drop a real error. It writes the status word with bit 25 at 0 while idle, which catches a design that lets software clear the idle flag. It also switches `txMode` while the inactive buffer is full, which exposes a design that detects overflow in both directions at once. Random traffic around these cases compares every read and every `irq` cycle against a reference model in the bench.

// File: rtl/audio_buf_pkg.sv
package audio_buf_pkg;

  // register addresses
  localparam int ADDR_CTRL   = 0;
  localparam int ADDR_STATUS = 1;
  localparam int ADDR_RXDATA = 2;
  localparam int ADDR_TXDATA = 3;

  // bit positions
  localparam int OVF_BIT     = 26;
  localparam int IDLE_BIT    = 25;
  localparam int RXFULL_BIT  = 0;
  localparam int TXFULL_BIT  = 1;
  localparam int OVFEN_BIT   = 0;
  localparam int IDLEEN_BIT  = 1;

  typedef struct packed {
    logic loadRx;
    logic readRx;
    logic writeTx;
    logic takeTx;
    logic wrCtrl;
    logic wrStatus;
  } bufStrobes_t;

endpackage

// File: rtl/audio_buf_ctrl.sv
module audio_buf_ctrl
  import audio_buf_pkg::*;
#(
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txMode,
  input  logic              portIdle,
  input  logic              shiftRxValid,
  input  logic              shiftTxTake,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrOvfBit,
  input  logic              wrOvfEn,
  input  logic              wrIdleEn,
  input  logic              rxFull,
  input  logic              txFull,
  output bufStrobes_t       stb,
  output logic              ovfFlag,
  output logic              idleFlag,
  output logic              ovfIntEn,
  output logic              idleIntEn,
  output logic              irq
);

  logic ovfEvent;
  logic clearReq;

  always_comb begin
    stb          = '0;
    stb.loadRx   = shiftRxValid;
    stb.takeTx   = shiftTxTake;
    stb.readRx   = regRdEn && (regAddr == ADDR_W'(ADDR_RXDATA));
    stb.writeTx  = regWrEn && (regAddr == ADDR_W'(ADDR_TXDATA));
    stb.wrCtrl   = regWrEn && (regAddr == ADDR_W'(ADDR_CTRL));
    stb.wrStatus = regWrEn && (regAddr == ADDR_W'(ADDR_STATUS));
  end

  // a same-cycle read or take drains the old word, so no loss
  always_comb begin
    if (txMode) ovfEvent = stb.writeTx && txFull && !stb.takeTx;
    else        ovfEvent = stb.loadRx  && rxFull && !stb.readRx;
    clearReq = stb.wrStatus && !wrOvfBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ovfFlag   <= 1'b0;
      idleFlag  <= 1'b0;
      ovfIntEn  <= 1'b0;
      idleIntEn <= 1'b0;
      irq       <= 1'b0;
    end else begin
      if (stb.wrCtrl) begin
        ovfIntEn  <= wrOvfEn;
        idleIntEn <= wrIdleEn;
      end
      if (ovfEvent)      ovfFlag <= 1'b1;
      else if (clearReq) ovfFlag <= 1'b0;
      idleFlag <= portIdle;
      irq      <= (ovfFlag && ovfIntEn) || (idleFlag && idleIntEn);
    end
  end

  // R2: an event sets the flag on the next edge, enable or not
  a_r2_ovf_sets: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvent |=> ovfFlag);

  // R5: receive loads in transmit mode never raise the flag
  a_r5_mode_gate: assert property (@(posedge clk) disable iff (!rstN)
    (txMode && !ovfFlag && !stb.writeTx) |=> !ovfFlag);

  // R6: without a clearing write the flag is sticky
  a_r6_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !stb.wrStatus) |=> ovfFlag);

  // R7: idle flag tracks the input one cycle later
  a_r7_idle_follow: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (idleFlag == $past(portIdle)));

  // R8: enabled flags reach the interrupt line
  a_r8_irq_ovf: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && ovfIntEn) |=> irq);

  a_r8_irq_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (!ovfIntEn && !idleIntEn) |=> !irq);

endmodule

// File: rtl/audio_buf_data.sv
module audio_buf_data
  import audio_buf_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobes_t       stb,
  input  logic [DATA_W-1:0] shiftRxData,
  input  logic [DATA_W-1:0] wrWord,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              ovfFlag,
  input  logic              idleFlag,
  input  logic              ovfIntEn,
  input  logic              idleIntEn,
  output logic              rxFull,
  output logic              txFull,
  output logic [DATA_W-1:0] shiftTxData,
  output logic [BUS_W-1:0]  regRdData
);

  logic [DATA_W-1:0] rxWord;
  logic [DATA_W-1:0] txWord;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxWord <= '0;
      txWord <= '0;
      rxFull <= 1'b0;
      txFull <= 1'b0;
    end else begin
      if (stb.loadRx)      begin rxWord <= shiftRxData; rxFull <= 1'b1; end
      else if (stb.readRx) rxFull <= 1'b0;
      if (stb.writeTx)     begin txWord <= wrWord; txFull <= 1'b1; end
      else if (stb.takeTx) txFull <= 1'b0;
    end
  end

  assign shiftTxData = txWord;

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_W'(ADDR_CTRL): begin
        regRdData[OVFEN_BIT]  = ovfIntEn;
        regRdData[IDLEEN_BIT] = idleIntEn;
      end
      ADDR_W'(ADDR_STATUS): begin
        regRdData[OVF_BIT]    = ovfFlag;
        regRdData[IDLE_BIT]   = idleFlag;
        regRdData[RXFULL_BIT] = rxFull;
        regRdData[TXFULL_BIT] = txFull;
      end
      ADDR_W'(ADDR_RXDATA): regRdData[DATA_W-1:0] = rxWord;
      ADDR_W'(ADDR_TXDATA): regRdData[DATA_W-1:0] = txWord;
      default: regRdData = '0;
    endcase
  end

  // R3: a load always lands the new word
  a_r3_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadRx |=> (rxWord == $past(shiftRxData)));

  // R9: read without load empties the receive buffer
  a_r9_rx_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.readRx && !stb.loadRx) |=> !rxFull);

  // R9: take without write empties the transmit buffer
  a_r9_tx_clear: assert property (@(posedge clk) disable iff (!rstN)
    (stb.takeTx && !stb.writeTx) |=> !txFull);

  // R4: a write always fills the transmit buffer
  a_r4_tx_fill: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeTx |=> (txFull && txWord == $past(wrWord)));

endmodule

// File: rtl/audio_buf_status.sv
module audio_buf_status
  import audio_buf_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int BUS_W  = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txMode,
  input  logic              portIdle,
  input  logic              shiftRxValid,
  input  logic [DATA_W-1:0] shiftRxData,
  input  logic              shiftTxTake,
  output logic [DATA_W-1:0] shiftTxData,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [BUS_W-1:0]  regWrData,
  output logic [BUS_W-1:0]  regRdData,
  output logic              irq
);

  bufStrobes_t stb;
  logic rxFull, txFull, ovfFlag, idleFlag, ovfIntEn, idleIntEn;
  logic unusedWrBits;

  assign unusedWrBits = ^regWrData;

  audio_buf_ctrl #(.ADDR_W(ADDR_W)) uCtrl (
    .clk(clk), .rstN(rstN), .txMode(txMode), .portIdle(portIdle),
    .shiftRxValid(shiftRxValid), .shiftTxTake(shiftTxTake),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .wrOvfBit(regWrData[OVF_BIT]), .wrOvfEn(regWrData[OVFEN_BIT]),
    .wrIdleEn(regWrData[IDLEEN_BIT]),
    .rxFull(rxFull), .txFull(txFull), .stb(stb),
    .ovfFlag(ovfFlag), .idleFlag(idleFlag),
    .ovfIntEn(ovfIntEn), .idleIntEn(idleIntEn), .irq(irq)
  );

  audio_buf_data #(.DATA_W(DATA_W), .BUS_W(BUS_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .shiftRxData(shiftRxData),
    .wrWord(regWrData[DATA_W-1:0]), .regAddr(regAddr),
    .ovfFlag(ovfFlag), .idleFlag(idleFlag),
    .ovfIntEn(ovfIntEn), .idleIntEn(idleIntEn),
    .rxFull(rxFull), .txFull(txFull),
    .shiftTxData(shiftTxData), .regRdData(regRdData)
  );

endmodule

// File: tb/sim_audio_buf_status.sv
`timescale 1ns/1ps
module sim_audio_buf_status;

  localparam int DW = 24;
  localparam int BW = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txMode = 1'b0, portIdle = 1'b0, shiftRxValid = 1'b0, shiftTxTake = 1'b0;
  logic [DW-1:0] shiftRxData = '0;
  logic [DW-1:0] shiftTxData;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [BW-1:0] regWrData = '0;
  logic [BW-1:0] regRdData;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // reference state
  bit mOvf, mIdle, mOEn, mIEn, mIrq, mRxF, mTxF;
  logic [DW-1:0] mRx, mTx;

  always #10 clk = ~clk;

  audio_buf_status u0 (
    .clk(clk), .rstN(rstN), .txMode(txMode), .portIdle(portIdle),
    .shiftRxValid(shiftRxValid), .shiftRxData(shiftRxData),
    .shiftTxTake(shiftTxTake), .shiftTxData(shiftTxData),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  function automatic logic [BW-1:0] expRead(input logic [1:0] a);
    logic [BW-1:0] v = '0;
    case (a)
      2'd0: begin v[0] = mOEn; v[1] = mIEn; end
      2'd1: begin v[26] = mOvf; v[25] = mIdle; v[0] = mRxF; v[1] = mTxF; end
      2'd2: v[DW-1:0] = mRx;
      default: v[DW-1:0] = mTx;
    endcase
    return v;
  endfunction

  function automatic string tagFor(input logic [1:0] a);
    case (a)
      2'd0: return "R10";
      2'd1: return "R2";
      2'd2: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [BW-1:0] act,
                     input logic [BW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  // one bus cycle; read data checked before the edge, irq/shift after
  task automatic cyc(input bit mode, input bit rxV, input logic [DW-1:0] rxD,
                     input bit take, input bit idle, input bit wr,
                     input logic [1:0] addr, input logic [BW-1:0] wd,
                     input bit rd, input string tag);
    bit ldRx, rdRx, wrTx, ev;
    bit nOvf, nIrq;
    logic [BW-1:0] e;
    @(negedge clk);
    txMode = mode; shiftRxValid = rxV; shiftRxData = rxD; shiftTxTake = take;
    portIdle = idle; regWrEn = wr; regAddr = addr; regWrData = wd; regRdEn = rd;
    #1;
    e = expRead(addr);
    chk(regRdData == e, (tag == "") ? tagFor(addr) : tag, regRdData, e);
    ldRx = rxV; rdRx = rd && addr == 2'd2; wrTx = wr && addr == 2'd3;
    ev   = mode ? (wrTx && mTxF && !take) : (ldRx && mRxF && !rdRx);
    nIrq = (mOvf && mOEn) || (mIdle && mIEn);
    nOvf = ev ? 1'b1 : ((wr && addr == 2'd1 && !wd[26]) ? 1'b0 : mOvf);
    @(posedge clk);
    mIrq = nIrq; mOvf = nOvf; mIdle = idle;
    if (wr && addr == 2'd0) begin mOEn = wd[0]; mIEn = wd[1]; end
    if (ldRx) begin mRx = rxD; mRxF = 1'b1; end else if (rdRx) mRxF = 1'b0;
    if (wrTx) begin mTx = wd[DW-1:0]; mTxF = 1'b1; end else if (take) mTxF = 1'b0;
    #1;
    chk(irq == mIrq, "R8", BW'(irq), BW'(mIrq));
    chk(shiftTxData == mTx, "R9", BW'(shiftTxData), BW'(mTx));
  endtask

  task automatic idleCyc(input bit mode, input logic [1:0] addr, input string tag);
    cyc(mode, 0, '0, 0, mIdle, 0, addr, '0, 0, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd20240611);
    {mOvf, mIdle, mOEn, mIEn, mIrq, mRxF, mTxF} = '0;
    mRx = '0; mTx = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;

    // R1: reset state on every register and the interrupt line
    #1;
    chk(irq == 1'b0, "R1", BW'(irq), '0);
    idleCyc(0, 2'd1, "R1");
    idleCyc(0, 2'd0, "R1");
    idleCyc(0, 2'd3, "R1");

    // R3: overflow in receive mode, new word kept
    cyc(0, 1, 24'h111111, 0, 0, 0, 2'd1, '0, 0, "R3");
    cyc(0, 1, 24'h222222, 0, 0, 0, 2'd1, '0, 0, "R3");
    idleCyc(0, 2'd1, "R3");
    idleCyc(0, 2'd2, "R3");
    // R6: writing 1 keeps the flag, writing 0 clears it
    cyc(0, 0, '0, 0, 0, 1, 2'd1, 32'h0400_0000, 0, "R6");
    idleCyc(0, 2'd1, "R6");
    cyc(0, 0, '0, 0, 0, 1, 2'd1, 32'h0000_0000, 0, "R6");
    idleCyc(0, 2'd1, "R6");
    // R9: read and load in one cycle is no overflow
    cyc(0, 1, 24'h333333, 0, 0, 0, 2'd2, '0, 1, "R9");
    idleCyc(0, 2'd1, "R9");
    cyc(0, 0, '0, 0, 0, 0, 2'd2, '0, 1, "R9");
    idleCyc(0, 2'd1, "R9");
    // R6: clear and overflow in one cycle, the set wins
    cyc(0, 1, 24'h444444, 0, 0, 0, 2'd1, '0, 0, "R6");
    cyc(0, 1, 24'h555555, 0, 0, 1, 2'd1, 32'h0, 0, "R6");
    idleCyc(0, 2'd1, "R6");
    cyc(0, 0, '0, 0, 0, 1, 2'd1, 32'h0, 0, "R6");
    // R5: rx buffer full, loads in transmit mode do not overflow
    cyc(1, 1, 24'h666666, 0, 0, 0, 2'd1, '0, 0, "R5");
    idleCyc(1, 2'd1, "R5");
    // R4: transmit overflow, and take with write is no overflow
    cyc(1, 0, '0, 0, 0, 1, 2'd3, 32'h00AA_0001, 0, "R4");
    cyc(1, 0, '0, 1, 0, 1, 2'd3, 32'h00AA_0002, 0, "R4");
    idleCyc(1, 2'd1, "R4");
    cyc(1, 0, '0, 0, 0, 1, 2'd3, 32'h00AA_0003, 0, "R4");
    idleCyc(1, 2'd1, "R4");
    // R5: tx buffer full, writes in receive mode do not overflow
    cyc(0, 0, '0, 0, 0, 1, 2'd1, 32'h0, 0, "R5");
    cyc(0, 0, '0, 0, 0, 1, 2'd3, 32'h00AA_0004, 0, "R5");
    idleCyc(0, 2'd1, "R5");
    // R7: idle follows input, write of 0 does not clear it
    cyc(0, 0, '0, 0, 1, 0, 2'd1, '0, 0, "R7");
    cyc(0, 0, '0, 0, 1, 1, 2'd1, 32'h0, 0, "R7");
    idleCyc(0, 2'd1, "R7");
    // R8/R10: enable the idle interrupt, then mask it
    cyc(0, 0, '0, 0, 1, 1, 2'd0, 32'h2, 0, "R10");
    idleCyc(0, 2'd0, "R10");
    idleCyc(0, 2'd1, "R8");
    cyc(0, 0, '0, 0, 1, 1, 2'd0, 32'h1, 0, "R10");
    idleCyc(0, 2'd0, "R8");
    idleCyc(0, 2'd0, "R8");

    // random traffic
    for (int i = 0; i < 4000; i++) begin
      bit mode, rxV, take, idle, wr, rd;
      logic [1:0] a;
      logic [BW-1:0] wd;
      mode = ($urandom % 16 == 0) ? ~txMode : txMode;
      rxV  = ($urandom % 3 == 0);
      take = ($urandom % 3 == 0);
      idle = ($urandom % 8 == 0) ? ~portIdle : portIdle;
      wr   = ($urandom % 4 == 0);
      rd   = ($urandom % 2 == 0);
      a    = 2'($urandom);
      wd   = $urandom;
      cyc(mode, rxV, DW'($urandom), take, idle, wr, a, wd, rd, "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule